// File: doc/BRIEF.md
# Priority Threshold Claim Arbiter

This block picks the interrupt that one target context would receive if it claimed now. It takes a vector of eligible sources, where each bit says that the source is pending, not already claimed and enabled for this context. It also takes a packed array of 3-bit source priorities and the context's 3-bit threshold. A source competes only if its priority is strictly above the threshold. Among the competitors, the one with the highest priority wins, and a tie goes to the lowest source ID.

ID 0 is reserved to mean "nothing to claim". Source slot 0 therefore never competes. The search is a balanced binary max-tree, and its result is registered, so the outputs follow the inputs with one cycle of latency. A mode input binds the context to machine or supervisor privilege. The request then drives the external-interrupt line of that mode only. One instance is placed per context. State storage and bus access live elsewhere.

Top module: `prio_claim_arbiter`

## Requirements
- R1: `irq_req_o` is high exactly when some eligible source with ID 1 or above has a priority strictly greater than `threshold_i`, judged on the inputs present at the previous rising clock edge.
- R2: When `irq_req_o` is high, `claim_id_o` names an eligible source whose priority is the largest among all qualifying sources.
- R3: When several qualifying sources share the largest priority, `claim_id_o` is the lowest of their IDs.
- R4: When no source qualifies, `claim_id_o` is 0 and `irq_req_o` is low.
- R5: The priority comparison is strict. A source whose priority equals the threshold does not qualify. A priority of 0 never qualifies. A threshold of 7 blocks every source.
- R6: Source slot 0 (bit 0 of `eligible_i`, priority bits [2:0]) is reserved and has no effect on any output.
- R7: With `ctx_mode_i`=1 (machine), `meip_o` equals the request and `seip_o` is 0. With `ctx_mode_i`=0 (supervisor), `seip_o` equals the request and `meip_o` is 0.
- R8: Every output is registered, with one cycle of latency from the inputs. An active-low `rst_n` clears all outputs to 0 at once, even with qualifying inputs held.

The priority of source i sits at `prio_i[3*i+2 : 3*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| eligible_i | input | NUM_SRC | Per-source eligibility (pending, not claimed, enabled) |
| prio_i | input | 3*NUM_SRC | Packed source priorities, 3 bits per source |
| threshold_i | input | 3 | Context priority threshold |
| ctx_mode_i | input | 1 | Context privilege: 1 machine, 0 supervisor |
| irq_req_o | output | 1 | Context interrupt request |
| claim_id_o | output | $clog2(NUM_SRC) | ID a claim would return, 0 if none |
| meip_o | output | 1 | Machine external-interrupt line |
| seip_o | output | 1 | Supervisor external-interrupt line |

## Verification
The hardest case to reach is a tie at the top priority while a lower-ID source holds a lesser priority and a higher-ID source holds a greater one. A winner there must be checked against both a strict and a non-strict comparison. Directed patterns place equal priorities in different subtrees of the tree and then raise a later source by one level. Threshold-equal and priority-0 cases are also directed. Several hundred random vectors of eligibility, priority, threshold and mode are then applied back to back. Each vector is scored one cycle later against a linear scan that replaces its running winner only on a strictly greater priority.

// File: rtl/pca_pkg.sv
`timescale 1ns/1ps
package pca_pkg;
  localparam int PRIO_W  = 3;
  localparam int MAX_SRC = 64;
  localparam logic MODE_MACHINE = 1'b1;

  // strict comparison shared by leaf qualification and node merging
  function automatic logic prio_beats(input logic [PRIO_W-1:0] a,
                                      input logic [PRIO_W-1:0] b);
    return a > b;
  endfunction
endpackage

// File: rtl/pca_rst_sync.sv
`timescale 1ns/1ps
module pca_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic s1_q;
  logic s1_d;
  assign s1_d = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      s1_q    <= s1_d;
      rst_q_n <= s1_q;
    end
  end
endmodule

// File: rtl/pca_leaf.sv
`timescale 1ns/1ps
module pca_leaf
  import pca_pkg::*;
#(
  parameter int IDW      = 5,
  parameter int SRC_ID   = 1,
  parameter bit RESERVED = 1'b0
) (
  input  logic              elig_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0] thr_i,
  output logic              valid_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [IDW-1:0]    id_o
);
  always_comb begin
    valid_o = !RESERVED && elig_i && prio_beats(prio_i, thr_i);
    prio_o  = prio_i;
    id_o    = IDW'(SRC_ID);
  end
endmodule

// File: rtl/pca_merge.sv
`timescale 1ns/1ps
module pca_merge
  import pca_pkg::*;
#(
  parameter int IDW = 5
) (
  input  logic              l_v_i,
  input  logic [PRIO_W-1:0] l_p_i,
  input  logic [IDW-1:0]    l_id_i,
  input  logic              r_v_i,
  input  logic [PRIO_W-1:0] r_p_i,
  input  logic [IDW-1:0]    r_id_i,
  output logic              v_o,
  output logic [PRIO_W-1:0] p_o,
  output logic [IDW-1:0]    id_o
);
  logic take_r;
  // left subtree holds lower IDs: right wins only on strictly higher priority
  always_comb begin
    take_r = r_v_i && (!l_v_i || prio_beats(r_p_i, l_p_i));
    v_o    = l_v_i || r_v_i;
    p_o    = take_r ? r_p_i  : l_p_i;
    id_o   = take_r ? r_id_i : l_id_i;
  end
endmodule

// File: rtl/pca_tree.sv
`timescale 1ns/1ps
module pca_tree
  import pca_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int IDW     = 5
) (
  input  logic [NUM_SRC-1:0]        elig_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]         thr_i,
  output logic                      win_v_o,
  output logic [PRIO_W-1:0]         win_p_o,
  output logic [IDW-1:0]            win_id_o
);
  localparam int LEAVES = 1 << IDW;
  localparam int NODES  = 2 * LEAVES - 1;
  localparam int FIRST  = LEAVES - 1;

  logic              nd_v  [NODES];
  logic [PRIO_W-1:0] nd_p  [NODES];
  logic [IDW-1:0]    nd_id [NODES];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < NUM_SRC) begin : g_real
      pca_leaf #(.IDW(IDW), .SRC_ID(i), .RESERVED(i == 0)) u_leaf (
        .elig_i (elig_i[i]),
        .prio_i (prio_i[i*PRIO_W +: PRIO_W]),
        .thr_i  (thr_i),
        .valid_o(nd_v[FIRST+i]),
        .prio_o (nd_p[FIRST+i]),
        .id_o   (nd_id[FIRST+i])
      );
    end else begin : g_pad
      assign nd_v[FIRST+i]  = 1'b0;
      assign nd_p[FIRST+i]  = '0;
      assign nd_id[FIRST+i] = IDW'(i);
    end
  end

  for (genvar k = 0; k < FIRST; k++) begin : g_node
    pca_merge #(.IDW(IDW)) u_merge (
      .l_v_i (nd_v[2*k+1]),
      .l_p_i (nd_p[2*k+1]),
      .l_id_i(nd_id[2*k+1]),
      .r_v_i (nd_v[2*k+2]),
      .r_p_i (nd_p[2*k+2]),
      .r_id_i(nd_id[2*k+2]),
      .v_o   (nd_v[k]),
      .p_o   (nd_p[k]),
      .id_o  (nd_id[k])
    );
  end

  assign win_v_o  = nd_v[0];
  assign win_p_o  = nd_p[0];
  assign win_id_o = nd_id[0];
endmodule

// File: rtl/prio_claim_arbiter.sv
`timescale 1ns/1ps
module prio_claim_arbiter
  import pca_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int IDW    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        eligible_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]         threshold_i,
  input  logic                      ctx_mode_i,
  output logic                      irq_req_o,
  output logic [IDW-1:0]            claim_id_o,
  output logic                      meip_o,
  output logic                      seip_o
);
  logic              rst_q_n;
  logic              win_v;
  logic [PRIO_W-1:0] win_p;
  logic [IDW-1:0]    win_id;

  logic              req_d, me_d, se_d, upd;
  logic [IDW-1:0]    id_d;

  pca_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  pca_tree #(.NUM_SRC(NUM_SRC), .IDW(IDW)) u_tree (
    .elig_i  (eligible_i),
    .prio_i  (prio_i),
    .thr_i   (threshold_i),
    .win_v_o (win_v),
    .win_p_o (win_p),
    .win_id_o(win_id)
  );

  // next-state
  always_comb begin
    req_d = win_v;
    id_d  = win_v ? win_id : '0;
    me_d  = win_v && (ctx_mode_i == MODE_MACHINE);
    se_d  = win_v && (ctx_mode_i != MODE_MACHINE);
    upd   = (req_d != irq_req_o) || (id_d != claim_id_o) ||
            (me_d != meip_o) || (se_d != seip_o);
  end

  // registers with explicit enable
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      irq_req_o  <= 1'b0;
      claim_id_o <= '0;
      meip_o     <= 1'b0;
      seip_o     <= 1'b0;
    end else if (upd) begin
      irq_req_o  <= req_d;
      claim_id_o <= id_d;
      meip_o     <= me_d;
      seip_o     <= se_d;
    end
  end

  // ---------------- assertions ----------------
  logic                      armed_q;
  logic [NUM_SRC-1:0]        chk_elig_q;
  logic [NUM_SRC*PRIO_W-1:0] chk_prio_q;
  logic [PRIO_W-1:0]         chk_thr_q;
  logic                      chk_mode_q;
  logic                      chk_any, chk_better;
  logic [PRIO_W-1:0]         chk_wp;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      armed_q    <= 1'b0;
      chk_elig_q <= '0;
      chk_prio_q <= '0;
      chk_thr_q  <= '0;
      chk_mode_q <= 1'b0;
    end else begin
      armed_q    <= 1'b1;
      chk_elig_q <= eligible_i;
      chk_prio_q <= prio_i;
      chk_thr_q  <= threshold_i;
      chk_mode_q <= ctx_mode_i;
    end
  end

  // flat scan over the sampled inputs, independent of the tree
  always_comb begin
    chk_any    = 1'b0;
    chk_better = 1'b0;
    chk_wp     = chk_prio_q[int'(claim_id_o)*PRIO_W +: PRIO_W];
    for (int j = 1; j < NUM_SRC; j++) begin
      if (chk_elig_q[j] && chk_prio_q[j*PRIO_W +: PRIO_W] > chk_thr_q) begin
        chk_any = 1'b1;
        if (chk_prio_q[j*PRIO_W +: PRIO_W] > chk_wp ||
            (chk_prio_q[j*PRIO_W +: PRIO_W] == chk_wp && j < int'(claim_id_o)))
          chk_better = 1'b1;
      end
    end
  end

  AST_REQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_q_n || !armed_q) irq_req_o == chk_any); // R1
  AST_WIN_QUALIFIES: assert property (@(posedge clk) disable iff (!rst_q_n || !armed_q) irq_req_o |-> (chk_elig_q[claim_id_o] && chk_wp > chk_thr_q && claim_id_o != '0)); // R2
  AST_NO_BETTER: assert property (@(posedge clk) disable iff (!rst_q_n || !armed_q) irq_req_o |-> !chk_better); // R3
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n) !irq_req_o |-> claim_id_o == '0); // R4
  AST_MODE_SPLIT: assert property (@(posedge clk) disable iff (!rst_q_n) $onehot0({meip_o, seip_o}) && ((meip_o || seip_o) == irq_req_o)); // R7
  AST_MODE_SEL: assert property (@(posedge clk) disable iff (!rst_q_n || !armed_q) meip_o |-> chk_mode_q); // R7
endmodule

// File: tb/tb_prio_claim_arbiter.sv
`timescale 1ns/1ps
module tb_prio_claim_arbiter;
  localparam int NS = 32;
  localparam int PW = 3;
  localparam int IW = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n;
  logic [NS-1:0]     d_elig;
  logic [NS*PW-1:0]  d_prio;
  logic [PW-1:0]     d_thr;
  logic              d_mode;
  logic              irq_req, meip, seip;
  logic [IW-1:0]     claim_id;

  prio_claim_arbiter #(.NUM_SRC(NS)) dut (
    .clk(clk), .rst_n(rst_n), .eligible_i(d_elig), .prio_i(d_prio),
    .threshold_i(d_thr), .ctx_mode_i(d_mode), .irq_req_o(irq_req),
    .claim_id_o(claim_id), .meip_o(meip), .seip_o(seip)
  );

  typedef struct {
    logic          req;
    logic [IW-1:0] id;
    logic          me;
    logic          se;
    string         tag;
  } exp_t;

  exp_t sbq[$];
  int total = 0;
  int bad   = 0;
  logic [NS-1:0]    s_elig;
  logic [NS*PW-1:0] s_prio;

  function automatic logic [IW-1:0] model_id(logic [NS-1:0] e, logic [NS*PW-1:0] p,
                                             logic [PW-1:0] t);
    logic [IW-1:0] best;
    logic [PW-1:0] bp;
    best = '0;
    bp   = t;
    for (int i = 1; i < NS; i++)
      if (e[i] && p[i*PW +: PW] > bp) begin
        best = IW'(i);
        bp   = p[i*PW +: PW];
      end
    return best;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic set_p(int id, int p);
    s_prio[id*PW +: PW] = PW'(p);
  endtask

  task automatic clear_stage();
    s_elig = '0;
    s_prio = '0;
  endtask

  // driver: one vector per cycle, expectation pushed to the scoreboard
  task automatic apply(logic [PW-1:0] t, logic m, string tag);
    exp_t e;
    @(negedge clk);
    d_elig = s_elig;
    d_prio = s_prio;
    d_thr  = t;
    d_mode = m;
    e.id  = model_id(s_elig, s_prio, t);
    e.req = (e.id != '0);
    e.me  = e.req && m;
    e.se  = e.req && !m;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic drain();
    while (sbq.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  // monitor: outputs settle one register after the driving negedge
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        check(e.tag, "req",  32'(irq_req),  32'(e.req));
        check(e.tag, "id",   32'(claim_id), 32'(e.id));
        check(e.tag, "meip", 32'(meip),     32'(e.me));
        check(e.tag, "seip", 32'(seip),     32'(e.se));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n  = 1'b0;
    d_elig = '1;
    d_prio = '1;
    d_thr  = '0;
    d_mode = 1'b1;
    clear_stage();
    repeat (3) @(posedge clk);
    #1;
    check("R8", "reset req",  32'(irq_req),  0);
    check("R8", "reset id",   32'(claim_id), 0);
    check("R8", "reset meip", 32'(meip),     0);
    check("R8", "reset seip", 32'(seip),     0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1/R2: single source
    clear_stage(); set_p(5, 3); s_elig[5] = 1'b1;
    apply(3'd0, 1'b1, "R1");
    apply(3'd2, 1'b1, "R2");
    // R5: threshold equal to priority, then priority 0, then threshold 7
    apply(3'd3, 1'b1, "R5");
    clear_stage(); set_p(9, 0); s_elig[9] = 1'b1;
    apply(3'd0, 1'b1, "R5");
    // R3: tie between 7 and 20, lower source with lesser priority
    clear_stage(); set_p(3, 2); set_p(7, 6); set_p(20, 6);
    s_elig[3] = 1'b1; s_elig[7] = 1'b1; s_elig[20] = 1'b1;
    apply(3'd1, 1'b1, "R3");
    set_p(20, 7);
    apply(3'd1, 1'b1, "R2");
    // R4: high priorities but nothing eligible
    s_prio = '1; s_elig = '0;
    apply(3'd0, 1'b1, "R4");
    // R6: reserved slot 0 alone, then with a weak real source
    clear_stage(); set_p(0, 7); s_elig[0] = 1'b1;
    apply(3'd0, 1'b1, "R6");
    set_p(4, 1); s_elig[4] = 1'b1;
    apply(3'd0, 1'b1, "R6");
    // R7: mode selection
    clear_stage(); set_p(5, 3); s_elig[5] = 1'b1;
    apply(3'd0, 1'b0, "R7");
    apply(3'd0, 1'b1, "R7");
    apply(3'd0, 1'b0, "R7");
    // top ID, and threshold 7
    s_prio = '0; for (int i = 1; i < NS; i++) set_p(i, 6);
    set_p(NS-1, 7); s_elig = '1;
    apply(3'd5, 1'b1, "R2");
    apply(3'd6, 1'b1, "R2");
    apply(3'd7, 1'b1, "R5");
    apply(3'd5, 1'b1, "R8");
    // random back-to-back
    for (int n = 0; n < 400; n++) begin
      s_elig = $urandom();
      s_prio = {$urandom(), $urandom(), $urandom()};
      apply(PW'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), "R2");
    end
    drain();

    // R8: asynchronous reset with qualifying inputs held
    clear_stage(); set_p(12, 5); s_elig[12] = 1'b1;
    apply(3'd1, 1'b1, "R8");
    drain();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8", "async reset req",  32'(irq_req),  0);
    check("R8", "async reset id",   32'(claim_id), 0);
    check("R8", "async reset meip", 32'(meip),     0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    apply(3'd1, 1'b1, "R8");
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule